// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that produces a steady stream of equal periods for a processor system. The input clock is divided by sixteen. Each divided tick advances a 20-bit live counter. When the counter reaches the programmed limit, it returns to zero on the next tick. Each such wrap increments a 12-bit period counter and sets a wrap flag. The flag drives the interrupt output when interrupts are enabled.

Software reads the count through two views that return the same word: the period counter in bits 31:20 and the live counter in bits 19:0. The acknowledging view clears the period counter and the wrap flag. The image view changes nothing.

Clearing the run bit does not stop the counter at once. The current period runs to completion, and the counter then rests at zero. The register port is a plain synchronous bus with one read cycle of latency.

Top module: `periodic_timer`

## Requirements
- R1: After reset, every register reads 0, `rdData` is 0 and `irq` is 0.
- R2: While counting, the live count rises by exactly 1 every 16 clock cycles. The first step comes 16 cycles after the write that starts counting.
- R3: On a tick with the live count at or above the limit, the live count returns to 0, the period count rises by 1 and the wrap flag is set. The period is therefore limit+1 ticks.
- R4: The 12-bit period count wraps from 4095 to 0.
- R5: A read at offset 0x8 returns {period count in bits 31:20, live count in bits 19:0}. The same read clears the period count and the wrap flag.
- R6: A read at offset 0xC returns the same word as offset 0x8 and clears nothing.
- R7: `irq` is high exactly when the wrap flag is set and the interrupt-enable bit is 1. With interrupts disabled, counting continues and `irq` stays low.
- R8: After the run bit is cleared, counting continues until the live count next returns to 0. The count then holds at 0.
- R9: If an acknowledging read and a wrap fall in the same cycle, the wrap wins. The period count becomes 1 and the wrap flag stays set.
- R10: The mode register is at offset 0x0. It holds the limit in bits 19:0, the run bit in bit 24 and the interrupt-enable bit in bit 25; other bits read as 0. Writes to any other offset have no effect.
- R11: A read at offset 0x4 returns the wrap flag in bit 0 and zeros elsewhere. This read does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register byte offset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe; data appears on `rdData` one cycle later |
| rdData | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things:
- the live count only steps by one or drops to zero;
- every drop to zero sets the wrap flag and advances the period count;
- a stopped counter stays at zero;
- an acknowledging read leaves the period count at 0 or 1, and `irq` never rises without the flag.

Only the bench scenarios show the 16-cycle tick spacing and the exact words returned by each view. They also show the graceful stop from a mid-period position, the collision of an acknowledge with a wrap, the 4095-to-0 rollover, and that writes to other offsets leave the mode register and the count untouched.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
  // Strobes passed from the register control to the counting datapath.
  typedef struct packed {
    logic runEn;    // counting requested by software
    logic ackRead;  // acknowledging read of the value view this cycle
  } ptmrStrobe_t;
endpackage

// File: rtl/ptmr_datapath.sv
`timescale 1ns/1ps
module ptmr_datapath #(
  parameter int CNT_W    = 20,
  parameter int OVF_W    = 12,
  parameter int PRESCALE = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ptmr_pkg::ptmrStrobe_t  strobe,
  input  logic [CNT_W-1:0]       limit,
  output logic [CNT_W-1:0]       liveCnt,
  output logic [OVF_W-1:0]       periodCnt,
  output logic                   wrapFlag
);
  localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]  psQ;
  logic [CNT_W-1:0] liveQ;
  logic [OVF_W-1:0] perQ;
  logic             flagQ;
  logic             active;
  logic             tick;
  logic             wrap;

  // Keep running while enabled, or until the current period has finished.
  assign active = strobe.runEn || (liveQ != '0);
  assign tick   = active && (psQ == PS_LAST);
  assign wrap   = tick && (liveQ >= limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psQ <= '0;
    end else if (!active || tick) begin
      psQ <= '0;
    end else begin
      psQ <= psQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ <= '0;
    end else if (wrap) begin
      liveQ <= '0;
    end else if (tick) begin
      liveQ <= liveQ + 1'b1;
    end
  end

  // A wrap in the acknowledge cycle takes priority, so no period is lost.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perQ  <= '0;
      flagQ <= 1'b0;
    end else if (wrap) begin
      perQ  <= strobe.ackRead ? OVF_W'(1) : perQ + 1'b1;
      flagQ <= 1'b1;
    end else if (strobe.ackRead) begin
      perQ  <= '0;
      flagQ <= 1'b0;
    end
  end

  assign liveCnt   = liveQ;
  assign periodCnt = perQ;
  assign wrapFlag  = flagQ;
endmodule

// File: rtl/ptmr_ctrl.sv
`timescale 1ns/1ps
module ptmr_ctrl #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 20,
  parameter int OVF_W   = 12,
  parameter int RUN_BIT = 24,
  parameter int IRQ_BIT = 25
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   rdEn,
  output logic [DATA_W-1:0]      rdData,
  output logic                   irq,
  input  logic [CNT_W-1:0]       liveCnt,
  input  logic [OVF_W-1:0]       periodCnt,
  input  logic                   wrapFlag,
  output logic [CNT_W-1:0]       limit,
  output ptmr_pkg::ptmrStrobe_t  strobe
);
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_VAL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_IMG  = ADDR_W'(12);

  logic [CNT_W-1:0]  limitQ;
  logic              runQ;
  logic              irqEnQ;
  logic [DATA_W-1:0] modeWord;
  logic [DATA_W-1:0] valueWord;
  logic [DATA_W-1:0] readMux;
  logic              unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ <= '0;
      runQ   <= 1'b0;
      irqEnQ <= 1'b0;
    end else if (wrEn && (addr == OFS_MODE)) begin
      limitQ <= wrData[CNT_W-1:0];
      runQ   <= wrData[RUN_BIT];
      irqEnQ <= wrData[IRQ_BIT];
    end
  end

  always_comb begin
    modeWord                 = '0;
    modeWord[CNT_W-1:0]      = limitQ;
    modeWord[RUN_BIT]        = runQ;
    modeWord[IRQ_BIT]        = irqEnQ;
    valueWord                = '0;
    valueWord[CNT_W-1:0]     = liveCnt;
    valueWord[DATA_W-1 -: OVF_W] = periodCnt;
  end

  always_comb begin
    readMux = '0;
    if (addr == OFS_MODE) begin
      readMux = modeWord;
    end else if (addr == OFS_STAT) begin
      readMux[0] = wrapFlag;
    end else if ((addr == OFS_VAL) || (addr == OFS_IMG)) begin
      readMux = valueWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= rdEn ? readMux : '0;
    end
  end

  assign limit          = limitQ;
  assign strobe.runEn   = runQ;
  assign strobe.ackRead = rdEn && (addr == OFS_VAL);
  assign irq            = wrapFlag && irqEnQ;
endmodule

// File: rtl/periodic_timer.sv
`timescale 1ns/1ps
module periodic_timer #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 20,
  parameter int OVF_W    = 12,
  parameter int PRESCALE = 16,
  parameter int RUN_BIT  = 24,
  parameter int IRQ_BIT  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  ptmr_pkg::ptmrStrobe_t strobe;
  logic [CNT_W-1:0]      limit;
  logic [CNT_W-1:0]      liveCnt;
  logic [OVF_W-1:0]      periodCnt;
  logic                  wrapFlag;

  ptmr_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .OVF_W(OVF_W),
    .RUN_BIT(RUN_BIT), .IRQ_BIT(IRQ_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irq(irq),
    .liveCnt(liveCnt), .periodCnt(periodCnt), .wrapFlag(wrapFlag),
    .limit(limit), .strobe(strobe)
  );

  ptmr_datapath #(
    .CNT_W(CNT_W), .OVF_W(OVF_W), .PRESCALE(PRESCALE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .limit(limit),
    .liveCnt(liveCnt), .periodCnt(periodCnt), .wrapFlag(wrapFlag)
  );
endmodule

// File: rtl/ptmr_checker.sv
`timescale 1ns/1ps
module ptmr_checker #(
  parameter int CNT_W = 20,
  parameter int OVF_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  irq,
  input ptmr_pkg::ptmrStrobe_t strobe,
  input logic [CNT_W-1:0]      liveCnt,
  input logic [OVF_W-1:0]      periodCnt,
  input logic                  wrapFlag
);
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> wrapFlag);

  p_live_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt != $past(liveCnt)) |->
      ((liveCnt == CNT_W'($past(liveCnt) + 1'b1)) || (liveCnt == '0)));

  p_wrap_marks_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((liveCnt == '0) && ($past(liveCnt) != '0)) |->
      (wrapFlag && ((periodCnt == OVF_W'($past(periodCnt) + 1'b1)) ||
                    (periodCnt == OVF_W'(1)))));

  p_stop_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.runEn && (liveCnt == '0)) |=> (liveCnt == '0));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackRead |=> (periodCnt <= OVF_W'(1)));
endmodule

bind periodic_timer ptmr_checker #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .strobe(strobe),
  .liveCnt(liveCnt), .periodCnt(periodCnt), .wrapFlag(wrapFlag)
);

// File: tb/sim_periodic_timer.sv
`timescale 1ns/1ps
module sim_periodic_timer;
  localparam logic [3:0] A_MODE = 4'h0;
  localparam logic [3:0] A_STAT = 4'h4;
  localparam logic [3:0] A_VAL  = 4'h8;
  localparam logic [3:0] A_IMG  = 4'hC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        irq;

  int unsigned cyc = 0;
  int unsigned runStart = 0;
  int total = 0;
  int bad = 0;

  periodic_timer u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] modeWord(int unsigned lim, bit run, bit ie);
    return (32'(ie) << 25) | (32'(run) << 24) | (lim & 32'hFFFFF);
  endfunction

  // Expected value word after a given number of ticks for limit lim.
  function automatic logic [31:0] expWord(int unsigned ticks, int unsigned lim);
    int unsigned per = (ticks / (lim + 1)) % 4096;
    int unsigned live = ticks % (lim + 1);
    return {per[11:0], live[19:0]};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(logic [3:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // snap: edge count whose resulting state the read captures.
  task automatic readReg(logic [3:0] a, output logic [31:0] d, output int unsigned snap);
    snap = cyc; addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic waitTo(int unsigned n);
    while (cyc - runStart < n) @(negedge clk);
  endtask

  task automatic startRun(int unsigned lim, bit ie);
    writeReg(A_MODE, modeWord(lim, 1'b1, ie));
    runStart = cyc;
  endtask

  task automatic checkImage(string req, int unsigned lim);
    logic [31:0] d; int unsigned s;
    readReg(A_IMG, d, s);
    check(req, "image word", d, expWord((s - runStart) / 16, lim));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned s;
    int unsigned tk;
    void'($urandom(32'd4242));

    // R1: reset state
    doReset();
    check("R1", "irq after reset", 32'(irq), 32'h0);
    readReg(A_MODE, d, s); check("R1", "mode", d, 32'h0);
    readReg(A_STAT, d, s); check("R1", "status", d, 32'h0);
    readReg(A_VAL, d, s);  check("R1", "value", d, 32'h0);
    readReg(A_IMG, d, s);  check("R1", "image", d, 32'h0);

    // R10: field layout and ignored writes
    writeReg(A_MODE, 32'hFFFF_FFFF);
    readReg(A_MODE, d, s); check("R10", "mode mask", d, 32'h030F_FFFF);
    startRun(5, 1'b0);
    writeReg(A_STAT, 32'hFFFF_FFFF);
    writeReg(A_VAL, 32'hFFFF_FFFF);
    writeReg(A_IMG, 32'hFFFF_FFFF);
    writeReg(4'h6, 32'hFFFF_FFFF);
    readReg(A_MODE, d, s); check("R10", "mode after foreign writes", d, modeWord(5, 1'b1, 1'b0));
    waitTo(40);
    checkImage("R10", 5);

    // R2, R3, R6, R11, R7 (irq disabled)
    doReset();
    startRun(3, 1'b0);
    waitTo(15); checkImage("R2", 3);
    waitTo(31); checkImage("R2", 3);
    waitTo(66); checkImage("R3", 3);
    checkImage("R6", 3);
    readReg(A_STAT, d, s); check("R11", "status flag", d, 32'h1);
    readReg(A_STAT, d, s); check("R11", "status not cleared", d, 32'h1);
    check("R7", "irq masked", 32'(irq), 32'h0);
    checkImage("R6", 3);

    // R5 acknowledge, then R9 collision
    doReset();
    startRun(1, 1'b1);
    waitTo(83);
    check("R7", "irq enabled", 32'(irq), 32'h1);
    readReg(A_VAL, d, s); check("R5", "value word", d, {12'd2, 20'd1});
    readReg(A_IMG, d, s); check("R5", "after ack", d, {12'd0, 20'd1});
    readReg(A_STAT, d, s); check("R5", "flag cleared", d, 32'h0);
    check("R5", "irq cleared", 32'(irq), 32'h0);
    waitTo(127);
    readReg(A_VAL, d, s); check("R9", "value before wrap", d, {12'd1, 20'd1});
    readReg(A_IMG, d, s); check("R9", "wrap wins", d, {12'd1, 20'd0});
    readReg(A_STAT, d, s); check("R9", "flag kept", d, 32'h1);
    check("R9", "irq kept", 32'(irq), 32'h1);

    // R8 graceful stop
    doReset();
    startRun(9, 1'b0);
    waitTo(50);
    writeReg(A_MODE, modeWord(9, 1'b0, 1'b0));
    waitTo(100);
    readReg(A_IMG, d, s); tk = (s - runStart) / 16; if (tk > 10) tk = 10;
    check("R8", "still counting", d, expWord(tk, 9));
    waitTo(196);
    readReg(A_IMG, d, s); check("R8", "stopped at zero", d, {12'd1, 20'd0});
    waitTo(480);
    readReg(A_IMG, d, s); check("R8", "still held", d, {12'd1, 20'd0});

    // R4 period count rollover
    doReset();
    startRun(0, 1'b0);
    waitTo(16 * 4095 + 5); checkImage("R4", 0);
    waitTo(16 * 4098 + 5); checkImage("R4", 0);

    // Random limits, enables and run lengths (R2, R3, R7, R11)
    for (int i = 0; i < 24; i++) begin
      int unsigned lim;
      bit ie;
      int unsigned m;
      lim = $urandom_range(0, 15);
      ie  = 1'($urandom_range(0, 1));
      m   = $urandom_range(0, 500);
      doReset();
      startRun(lim, ie);
      waitTo(m);
      tk = (cyc - runStart) / 16;
      check("R7", "random irq", 32'(irq), 32'(ie && (tk >= lim + 1)));
      checkImage("R3", lim);
      readReg(A_STAT, d, s);
      check("R11", "random status", d, 32'(((s - runStart) / 16) >= lim + 1));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule